// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block is the software-facing register bank of a streaming convolution engine. It answers single-beat AXI4-Lite writes and reads on a 64-bit data bus. It keeps a control word, a read-only status word and sixteen 32-bit layer configuration words. The configuration words are driven in parallel to the compute core. A start request written by software is turned into a one-cycle pulse toward the core. The done and fault indications that come back from the core are captured and held until the next start.

Each 64-bit beat covers two adjacent 32-bit registers. The register whose byte offset has bit 2 clear sits on data bits 31:0, and its neighbour at offset+4 sits on bits 63:32. Byte strobes select which bytes are written. Sideband outputs give software-independent views of the accelerator state: a busy level, a fault level and a 4-bit status code.

Top module: `ctlreg_slave`

## Requirements
- R1: The write address and write data may be accepted in either order, in the same cycle or apart. The write takes effect, and bvalid rises with bresp 2'b00, on the clock edge after the one where the second of the two has been held. awready and wready are high only while that channel holds nothing and no response is pending.
- R2: bvalid stays high until a cycle with bready high and then falls. While it is high, neither awready nor wready is asserted.
- R3: Byte strobes apply per byte, and bytes with a low strobe keep their value. Within a beat at 8-byte aligned address A, the register at A uses data bits 31:0 (strobes 3:0) and the register at A+4 uses bits 63:32 (strobes 7:4).
- R4: A read is accepted when arready is high. arready is low exactly while rvalid is high. rvalid rises one edge after acceptance, with both registers of the aligned beat (offset A on bits 31:0, A+4 on bits 63:32) and rresp 2'b00. rvalid and rdata hold until rready.
- R5: Offsets 0x08, 0x0C and 0x50 upward are unmapped. They read as zero, and writes to them change nothing that can be read back.
- R6: Writes to the status register at 0x04 are ignored.
- R7: Offsets 0x10 to 0x4C hold configuration word n = (offset-0x10)/4, exported on cfg_o bits 32n+31:32n. Word 0 (0x10) is image width, word 1 (0x14) is image height and word 2 (0x18) is input channel count. They reset to zero.
- R8: A committed write to the control register at 0x00 with strobe bit 0 high and data bit 0 high asserts start_o for exactly one cycle, starting at the same edge as bvalid. Any other write does not pulse start_o. Control bits keep the written value.
- R9: A high done_i sets status bit 0 and a high fault_i sets status bit 31. Each stays set until a start pulse clears both. A start at the same edge wins over a done or fault.
- R10: The status word is {fault, 27 zeros, 0, fault, busy, done}. busy_o is control bit 0 AND NOT done. error_o is status bit 31. status_o is status bits 3:0. All are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | DATA_W | Write data |
| s_wstrb_i | input | DATA_W/8 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response code |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | DATA_W | Read data |
| s_rresp_o | output | 2 | Read response code |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| start_o | output | 1 | One-cycle start pulse to the core |
| cfg_o | output | NCFG*32 | Configuration words, word n on bits 32n+31:32n |
| done_i | input | 1 | Completion indication from the core |
| fault_i | input | 1 | Fault indication from the core |
| busy_o | output | 1 | Start requested and not yet done |
| error_o | output | 1 | Captured fault |
| status_o | output | 4 | Low four status bits |

## Verification
A held-channel flag left stale shows at once as a ready that stays low or a response that comes a cycle early or late. A stray byte-lane decode shows in cfg_o on the next edge, long before any read. A done or fault flag that is not cleared, or not held, shows on busy_o, error_o and status_o in the cycle after the start pulse or the core event. A read mux fault shows in rdata in the same cycle rvalid rises. Because the bench model tracks every output on every clock, each such fault is seen within one cycle of the stimulus that exposes it.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned WORD_BYTES = WORD_W / 8;

   typedef enum logic [1:0] {
      RESP_OKAY = 2'b00
   } resp_e;

   // status word: fault on the top bit and bit 2, busy on bit 1, done on bit 0
   function automatic logic [WORD_W-1:0] status_word(input logic done,
                                                     input logic busy,
                                                     input logic fault);
      logic [WORD_W-1:0] w;
      w           = '0;
      w[0]        = done;
      w[1]        = busy;
      w[2]        = fault;
      w[WORD_W-1] = fault;
      return w;
   endfunction

endpackage

// File: rtl/ctlreg_wr_port.sv
module ctlreg_wr_port #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 64
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   awaddr_i,
   input  logic                awvalid_i,
   output logic                awready_o,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [DATA_W/8-1:0] wstrb_i,
   input  logic                wvalid_i,
   output logic                wready_o,
   output logic                bvalid_o,
   input  logic                bready_i,
   output logic                commit_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [DATA_W-1:0]   data_o,
   output logic [DATA_W/8-1:0] strb_o
);

   logic                aw_held_q;
   logic                w_held_q;
   logic                bvalid_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [DATA_W/8-1:0] strb_q;

   assign awready_o = !aw_held_q && !bvalid_q;
   assign wready_o  = !w_held_q && !bvalid_q;
   assign commit_o  = aw_held_q && w_held_q;
   assign bvalid_o  = bvalid_q;
   assign addr_o    = addr_q;
   assign data_o    = data_q;
   assign strb_o    = strb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         aw_held_q <= 1'b0;
         w_held_q  <= 1'b0;
         bvalid_q  <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
         strb_q    <= '0;
      end else if (commit_o) begin
         aw_held_q <= 1'b0;
         w_held_q  <= 1'b0;
         bvalid_q  <= 1'b1;
      end else begin
         if (awvalid_i && awready_o) begin
            aw_held_q <= 1'b1;
            addr_q    <= awaddr_i;
         end
         if (wvalid_i && wready_o) begin
            w_held_q <= 1'b1;
            data_q   <= wdata_i;
            strb_q   <= wstrb_i;
         end
         if (bvalid_q && bready_i) begin
            bvalid_q <= 1'b0;
         end
      end
   end

   // R2: response waits for the master
   a_r2_bvalid_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      bvalid_o && !bready_i |=> bvalid_o);

   // R1: one response per captured write
   a_r1_single_resp : assert property (@(posedge clk_i) disable iff (!rst_ni)
      bvalid_o && bready_i |=> !bvalid_o);

endmodule

// File: rtl/ctlreg_rd_port.sv
module ctlreg_rd_port #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              arvalid_i,
   output logic              arready_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   input  logic              rready_i,
   input  logic [DATA_W-1:0] lookup_i
);

   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   assign arready_o = !rvalid_q;
   assign rvalid_o  = rvalid_q;
   assign rdata_o   = rdata_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (arvalid_i && arready_o) begin
         rvalid_q <= 1'b1;
         rdata_q  <= lookup_i;
      end else if (rvalid_q && rready_i) begin
         rvalid_q <= 1'b0;
      end
   end

   // R4: read data held until taken
   a_r4_rdata_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank import ctlreg_pkg::*; #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NCFG     = 16,
   parameter int unsigned CFG_BASE = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   commit_i,
   input  logic [ADDR_W-1:0]      wr_addr_i,
   input  logic [DATA_W-1:0]      wr_data_i,
   input  logic [DATA_W/8-1:0]    wr_strb_i,
   input  logic [ADDR_W-1:0]      rd_addr_i,
   output logic [DATA_W-1:0]      rd_data_o,
   input  logic                   done_i,
   input  logic                   fault_i,
   output logic                   start_o,
   output logic                   busy_o,
   output logic                   error_o,
   output logic [3:0]             code_o,
   output logic [NCFG*WORD_W-1:0] cfg_o
);

   localparam int unsigned LANES = DATA_W / WORD_W;
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] LANE_MASK = IDX_W'(LANES - 1);

   logic [WORD_W-1:0] ctrl_q;
   logic [WORD_W-1:0] cfg_q [NCFG];
   logic              done_q;
   logic              fault_q;
   logic              start_q;
   logic              start_fire;
   logic [WORD_W-1:0] stat_w;
   logic [IDX_W-1:0]  wr_base;
   logic [IDX_W-1:0]  rd_base;
   logic [IDX_W-1:0]  wr_idx [LANES];
   logic [IDX_W-1:0]  rd_idx [LANES];
   logic              unused_lsb;

   assign unused_lsb = ^{wr_addr_i[1:0], rd_addr_i[1:0]};
   assign wr_base    = wr_addr_i[ADDR_W-1:2] & ~LANE_MASK;
   assign rd_base    = rd_addr_i[ADDR_W-1:2] & ~LANE_MASK;

   // one word index per lane of the beat
   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      logic [WORD_W-1:0] lane_word;

      assign wr_idx[gl] = wr_base | IDX_W'(gl);
      assign rd_idx[gl] = rd_base | IDX_W'(gl);

      always_comb begin
         lane_word = '0;
         if (rd_idx[gl] == IDX_W'(0)) begin
            lane_word = ctrl_q;
         end else if (rd_idx[gl] == IDX_W'(1)) begin
            lane_word = stat_w;
         end
         for (int c = 0; c < NCFG; c++) begin
            if (rd_idx[gl] == IDX_W'(CFG_BASE + c)) begin
               lane_word = cfg_q[c];
            end
         end
      end

      assign rd_data_o[gl*WORD_W +: WORD_W] = lane_word;
   end

   for (genvar gc = 0; gc < NCFG; gc++) begin : g_cfg_out
      assign cfg_o[gc*WORD_W +: WORD_W] = cfg_q[gc];
   end

   // control word is word 0, lane 0 of beat 0
   assign start_fire = commit_i && (wr_base == '0) && wr_strb_i[0] && wr_data_i[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         for (int c = 0; c < NCFG; c++) begin
            cfg_q[c] <= '0;
         end
      end else if (commit_i) begin
         for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
               if (wr_strb_i[l*WORD_BYTES + b]) begin
                  if (wr_idx[l] == IDX_W'(0)) begin
                     ctrl_q[b*8 +: 8] <= wr_data_i[l*WORD_W + b*8 +: 8];
                  end
                  for (int c = 0; c < NCFG; c++) begin
                     if (wr_idx[l] == IDX_W'(CFG_BASE + c)) begin
                        cfg_q[c][b*8 +: 8] <= wr_data_i[l*WORD_W + b*8 +: 8];
                     end
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         start_q <= start_fire;
         if (start_fire) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
         end else begin
            if (done_i) begin
               done_q <= 1'b1;
            end
            if (fault_i) begin
               fault_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o  = ctrl_q[0] & ~done_q;
   assign stat_w  = status_word(done_q, busy_o, fault_q);
   assign start_o = start_q;
   assign error_o = stat_w[WORD_W-1];
   assign code_o  = stat_w[3:0];

   // R8: start never lasts two cycles
   a_r8_start_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !start_o);

   // R9: a start leaves both captured flags clear
   a_r9_start_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> !done_q && !fault_q);

   // R9: done is held until a start
   a_r9_done_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q && !start_fire |=> done_q);

   // R10: the core is busy right after a start
   a_r10_busy_on_start : assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |-> busy_o);

endmodule

// File: rtl/ctlreg_slave.sv
module ctlreg_slave import ctlreg_pkg::*; #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned NCFG     = 16,
   parameter int unsigned CFG_BASE = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [ADDR_W-1:0]      s_awaddr_i,
   input  logic                   s_awvalid_i,
   output logic                   s_awready_o,
   input  logic [DATA_W-1:0]      s_wdata_i,
   input  logic [DATA_W/8-1:0]    s_wstrb_i,
   input  logic                   s_wvalid_i,
   output logic                   s_wready_o,
   output logic [1:0]             s_bresp_o,
   output logic                   s_bvalid_o,
   input  logic                   s_bready_i,
   input  logic [ADDR_W-1:0]      s_araddr_i,
   input  logic                   s_arvalid_i,
   output logic                   s_arready_o,
   output logic [DATA_W-1:0]      s_rdata_o,
   output logic [1:0]             s_rresp_o,
   output logic                   s_rvalid_o,
   input  logic                   s_rready_i,
   output logic                   start_o,
   output logic [NCFG*WORD_W-1:0] cfg_o,
   input  logic                   done_i,
   input  logic                   fault_i,
   output logic                   busy_o,
   output logic                   error_o,
   output logic [3:0]             status_o
);

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
      $error("ctlreg_slave: DATA_W must be 32 or 64");
   end
   if (CFG_BASE < 2) begin : g_bad_base
      $error("ctlreg_slave: CFG_BASE overlaps control or status");
   end
   if ((CFG_BASE + NCFG) * WORD_BYTES > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ctlreg_slave: ADDR_W too narrow for the register map");
   end

   logic                commit;
   logic [ADDR_W-1:0]   wr_addr;
   logic [DATA_W-1:0]   wr_data;
   logic [DATA_W/8-1:0] wr_strb;
   logic [DATA_W-1:0]   lookup;

   ctlreg_wr_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_wr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .awaddr_i  (s_awaddr_i),
      .awvalid_i (s_awvalid_i),
      .awready_o (s_awready_o),
      .wdata_i   (s_wdata_i),
      .wstrb_i   (s_wstrb_i),
      .wvalid_i  (s_wvalid_i),
      .wready_o  (s_wready_o),
      .bvalid_o  (s_bvalid_o),
      .bready_i  (s_bready_i),
      .commit_o  (commit),
      .addr_o    (wr_addr),
      .data_o    (wr_data),
      .strb_o    (wr_strb)
   );

   ctlreg_rd_port #(
      .DATA_W (DATA_W)
   ) i_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arvalid_i (s_arvalid_i),
      .arready_o (s_arready_o),
      .rdata_o   (s_rdata_o),
      .rvalid_o  (s_rvalid_o),
      .rready_i  (s_rready_i),
      .lookup_i  (lookup)
   );

   ctlreg_bank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NCFG     (NCFG),
      .CFG_BASE (CFG_BASE)
   ) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .wr_strb_i (wr_strb),
      .rd_addr_i (s_araddr_i),
      .rd_data_o (lookup),
      .done_i    (done_i),
      .fault_i   (fault_i),
      .start_o   (start_o),
      .busy_o    (busy_o),
      .error_o   (error_o),
      .code_o    (status_o),
      .cfg_o     (cfg_o)
   );

   assign s_bresp_o = RESP_OKAY;
   assign s_rresp_o = RESP_OKAY;

endmodule

// File: tb/test_ctlreg_slave.sv
`timescale 1ns/1ps
module test_ctlreg_slave;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   awaddr = '0;
   logic         awvalid = 1'b0;
   logic         awready;
   logic [63:0]  wdata = '0;
   logic [7:0]   wstrb = '0;
   logic         wvalid = 1'b0;
   logic         wready;
   logic [1:0]   bresp;
   logic         bvalid;
   logic         bready = 1'b0;
   logic [7:0]   araddr = '0;
   logic         arvalid = 1'b0;
   logic         arready;
   logic [63:0]  rdata;
   logic [1:0]   rresp;
   logic         rvalid;
   logic         rready = 1'b0;
   logic         start;
   logic [511:0] cfg;
   logic         done_in = 1'b0;
   logic         fault_in = 1'b0;
   logic         busy;
   logic         err;
   logic [3:0]   code;

   int n_checks = 0;
   int n_fail   = 0;
   int n_starts = 0;

   always #4 clk = ~clk;

   ctlreg_slave i_ctlreg_slave (
      .clk_i(clk), .rst_ni(rst_n),
      .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
      .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
      .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
      .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
      .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
      .start_o(start), .cfg_o(cfg), .done_i(done_in), .fault_i(fault_in),
      .busy_o(busy), .error_o(err), .status_o(code)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_ctrl;
   logic [31:0] m_cfg [16];
   bit          m_done, m_err, m_start, m_awh, m_wh, m_bv, m_rv;
   logic [7:0]  m_addr;
   logic [63:0] m_data, m_rdata;
   logic [7:0]  m_strb;

   function automatic logic [31:0] mword(input int idx);
      if (idx == 0) return m_ctrl;
      if (idx == 1) return {m_err, 27'd0, 1'b0, m_err, m_ctrl[0] & ~m_done, m_done};
      if (idx >= 4 && idx < 20) return m_cfg[idx-4];
      return 32'd0;
   endfunction

   function automatic logic [511:0] mcfg();
      logic [511:0] v;
      for (int c = 0; c < 16; c++) v[c*32 +: 32] = m_cfg[c];
      return v;
   endfunction

   always @(negedge clk) begin
      int  base;
      int  idx;
      bit  commit, acc_aw, acc_w, fire;
      if (!rst_n) begin
         m_ctrl = '0; m_done = 0; m_err = 0; m_start = 0;
         m_awh = 0; m_wh = 0; m_bv = 0; m_rv = 0;
         m_addr = '0; m_data = '0; m_strb = '0; m_rdata = '0;
         for (int c = 0; c < 16; c++) m_cfg[c] = '0;
      end else begin
         if (start) n_starts++;
         chk(awready == (!m_awh && !m_bv), "R1 awready", 64'(awready), 64'(!m_awh && !m_bv));
         chk(wready == (!m_wh && !m_bv), "R1 wready", 64'(wready), 64'(!m_wh && !m_bv));
         chk(bvalid == m_bv, "R2 bvalid", 64'(bvalid), 64'(m_bv));
         chk(bresp == 2'b00, "R1 bresp", 64'(bresp), 64'd0);
         chk(arready == !m_rv, "R4 arready", 64'(arready), 64'(!m_rv));
         chk(rvalid == m_rv, "R4 rvalid", 64'(rvalid), 64'(m_rv));
         if (m_rv) begin
            chk(rdata == m_rdata, "R4 rdata", rdata, m_rdata);
            chk(rresp == 2'b00, "R4 rresp", 64'(rresp), 64'd0);
         end
         chk(start == m_start, "R8 start", 64'(start), 64'(m_start));
         chk(busy == (m_ctrl[0] & ~m_done), "R10 busy", 64'(busy), 64'(m_ctrl[0] & ~m_done));
         chk(err == m_err, "R10 error", 64'(err), 64'(m_err));
         chk(code == {1'b0, m_err, m_ctrl[0] & ~m_done, m_done}, "R10 status", 64'(code),
             64'({1'b0, m_err, m_ctrl[0] & ~m_done, m_done}));
         chk(cfg == mcfg(), "R7 cfg", cfg[63:0], mcfg() >> 0);

         acc_aw = awvalid && !m_awh && !m_bv;
         acc_w  = wvalid && !m_wh && !m_bv;
         commit = m_awh && m_wh;
         fire   = 0;
         if (!m_rv && arvalid) begin
            base    = int'(araddr[7:3]) * 2;
            m_rdata = {mword(base + 1), mword(base)};
            m_rv    = 1;
         end else if (m_rv && rready) begin
            m_rv = 0;
         end
         if (commit) begin
            base = int'(m_addr[7:3]) * 2;
            for (int l = 0; l < 2; l++) begin
               for (int b = 0; b < 4; b++) begin
                  if (m_strb[l*4 + b]) begin
                     idx = base + l;
                     if (idx == 0) m_ctrl[b*8 +: 8] = m_data[l*32 + b*8 +: 8];
                     else if (idx >= 4 && idx < 20) m_cfg[idx-4][b*8 +: 8] = m_data[l*32 + b*8 +: 8];
                  end
               end
            end
            fire  = (base == 0) && m_strb[0] && m_data[0];
            m_bv  = 1; m_awh = 0; m_wh = 0;
         end else if (m_bv && bready) begin
            m_bv = 0;
         end
         if (acc_aw) begin m_awh = 1; m_addr = awaddr; end
         if (acc_w)  begin m_wh = 1; m_data = wdata; m_strb = wstrb; end
         m_start = fire;
         if (fire) begin
            m_done = 0; m_err = 0;
         end else begin
            if (done_in)  m_done = 1;
            if (fault_in) m_err = 1;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic send_aw(input logic [7:0] a);
      awaddr = a; awvalid = 1'b1;
      do @(negedge clk); while (!awready);
      step(); awvalid = 1'b0;
   endtask

   task automatic send_w(input logic [63:0] d, input logic [7:0] s);
      wdata = d; wstrb = s; wvalid = 1'b1;
      do @(negedge clk); while (!wready);
      step(); wvalid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] s,
                     input int order, input int bdly);
      if (order == 0) begin
         fork send_aw(a); send_w(d, s); join
      end else if (order == 1) begin
         send_aw(a); repeat (2) step(); send_w(d, s);
      end else begin
         send_w(d, s); repeat (2) step(); send_aw(a);
      end
      repeat (bdly) step();
      bready = 1'b1;
      do @(negedge clk); while (!bvalid);
      step(); bready = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input int rdly, output logic [63:0] d);
      araddr = a; arvalid = 1'b1;
      do @(negedge clk); while (!arready);
      step(); arvalid = 1'b0;
      repeat (rdly) step();
      rready = 1'b1;
      do @(negedge clk); while (!rvalid);
      d = rdata;
      step(); rready = 1'b0;
   endtask

   task automatic pulse(input bit which_fault);
      if (which_fault) fault_in = 1'b1; else done_in = 1'b1;
      step();
      fault_in = 1'b0; done_in = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] d;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      @(negedge clk);
      chk(busy == 0 && err == 0 && code == 0, "R10 reset outputs", 64'({busy, err, code}), 64'd0);
      chk(bvalid == 0 && rvalid == 0 && start == 0, "R2 reset idle", 64'({bvalid, rvalid, start}), 64'd0);
      step();

      // R7: geometry words through one beat, both channels together
      wr(8'h10, 64'h00000070_000000E0, 8'hFF, 0, 0);
      rd(8'h10, 0, d);
      chk(d == 64'h00000070_000000E0, "R7 geometry read", d, 64'h00000070_000000E0);
      chk(cfg[63:0] == 64'h00000070_000000E0, "R7 cfg words 0,1", cfg[63:0], 64'h00000070_000000E0);

      // R1: address ahead of data, low lane only
      wr(8'h18, 64'hFFFFFFFF_00000003, 8'h0F, 1, 0);
      rd(8'h18, 2, d);
      chk(d == 64'h00000000_00000003, "R1 aw-first write", d, 64'h00000000_00000003);

      // R3: partial strobes
      wr(8'h18, 64'hAABBCCDD_11223344, 8'h05, 0, 0);
      rd(8'h18, 0, d);
      chk(d == 64'h00000000_00220044, "R3 bytes 0 and 2", d, 64'h00000000_00220044);
      wr(8'h1C, 64'hAB000000_00000000, 8'h80, 2, 2);
      rd(8'h18, 0, d);
      chk(d == 64'hAB000000_00220044, "R3 upper lane byte 7", d, 64'hAB000000_00220044);

      // top of the configuration range
      wr(8'h48, 64'h12345678_9ABCDEF0, 8'hFF, 0, 0);
      rd(8'h48, 1, d);
      chk(d == 64'h12345678_9ABCDEF0, "R7 last words", d, 64'h12345678_9ABCDEF0);
      chk(cfg[511:448] == 64'h12345678_9ABCDEF0, "R7 cfg words 14,15", cfg[511:448], 64'h12345678_9ABCDEF0);

      // R5: unmapped offsets
      wr(8'h08, 64'hFFFFFFFF_FFFFFFFF, 8'hFF, 0, 0);
      rd(8'h08, 0, d);
      chk(d == 64'd0, "R5 gap at 0x08", d, 64'd0);
      wr(8'h50, 64'hFFFFFFFF_FFFFFFFF, 8'hFF, 1, 0);
      rd(8'h50, 0, d);
      chk(d == 64'd0, "R5 beyond 0x4C", d, 64'd0);

      // R8: start, data first, delayed bready
      wr(8'h00, 64'h00000000_00000001, 8'h01, 2, 3);
      chk(n_starts == 1, "R8 one start pulse", 64'(n_starts), 64'd1);
      chk(busy == 1, "R10 busy after start", 64'(busy), 64'd1);

      // R9: done and fault capture
      pulse(0);
      step();
      chk(busy == 0 && code == 4'b0001, "R9 done captured", 64'({busy, code}), 64'h01);
      pulse(1);
      step();
      chk(err == 1 && code == 4'b0101, "R9 fault captured", 64'({err, code}), 64'h15);
      rd(8'h00, 0, d);
      chk(d == 64'h80000005_00000001, "R10 status word", d, 64'h80000005_00000001);

      // R6: status write ignored
      wr(8'h00, 64'hFFFFFFFF_00000000, 8'hF0, 0, 0);
      rd(8'h00, 0, d);
      chk(d == 64'h80000005_00000001, "R6 status unchanged", d, 64'h80000005_00000001);

      // R9: restart clears captured flags
      wr(8'h00, 64'h00000000_00000001, 8'h01, 0, 0);
      chk(n_starts == 2, "R9 second start", 64'(n_starts), 64'd2);
      chk(err == 0 && code == 4'b0010, "R9 flags cleared", 64'({err, code}), 64'h02);

      // R8: byte 1 only, no start
      wr(8'h00, 64'h00000000_00000101, 8'h02, 1, 0);
      chk(n_starts == 2, "R8 no start without byte 0", 64'(n_starts), 64'd2);
      rd(8'h00, 0, d);
      chk(d[31:0] == 32'h00000101, "R8 control kept", 64'(d[31:0]), 64'h101);

      // R8: clearing bit 0 gives no pulse, busy drops
      wr(8'h00, 64'd0, 8'h0F, 0, 1);
      chk(n_starts == 2 && busy == 0 && code == 4'b0000, "R8 stop write",
          64'({n_starts[3:0], busy, code}), 64'h40);

      repeat (4) step();
      summary();
      $finish;
   end

endmodule